// File: doc/BRIEF.md
# VLIW Bundle Fetch Stage

This block is the front end of a four-slot very-long-instruction-word pipeline. It keeps a 32-bit program counter, a local store of 128-bit instruction bundles, and the register that passes work to the decode stage. A bundle packs four 32-bit operations. The counter moves forward by one whole bundle (16 bytes) per fetch, or jumps to a target address that decode supplies.

The store has one port. The current program counter addresses that port for both writes and reads. To load a program, a host raises the fill strobe with a bundle on the fill-data input. It can step the counter between writes or leave it in place. A single enable freezes the counter and the decode-facing register together, so that hazard logic further down the pipeline can stall fetch. When nothing is read, or when a fill takes the port, the decode register receives a no-operation bundle.

Top module: `vliw_fetch`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and the registered next address to 0. It loads the registered bundle with the no-operation bundle, which is the NOP_OP word (default 32'hF000_0000) in each of the four slots.
- R2: On an edge with `pc_upd_en` high and `take_branch` low, the program counter becomes its old value plus 16, wrapping modulo 2^32.
- R3: On an edge with `pc_upd_en` high and `take_branch` high, the program counter becomes `branch_target`.
- R4: On an edge with `pc_upd_en` low, the program counter keeps its value, whatever `take_branch` and `branch_target` are.
- R5: On an edge with `fill_en` high, `fill_bundle` is written into store entry PC[10:4], whether or not fetch is frozen. PC[3:0] and PC[31:11] do not select the entry, so addresses that differ only in those bits reach the same entry.
- R6: When `fill_en` and `fetch_rd_en` are both high on an edge with `pc_upd_en` high, the write happens and the registered bundle becomes the no-operation bundle.
- R7: On an edge with `pc_upd_en` high, the registered next address becomes the old PC plus 16. With `fetch_rd_en` high and `fill_en` low, the registered bundle becomes store entry PC[10:4] as it was before that edge. With `fetch_rd_en` low, the registered bundle becomes the no-operation bundle.
- R8: On an edge with `pc_upd_en` low, the registered next address and the registered bundle both keep their values.
- R9: Slot k of a bundle occupies bits [32k+31:32k], both in the store and in the registered bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_upd_en | input | 1 | Advance enable; low freezes the PC and the decode register |
| take_branch | input | 1 | 1 selects branch_target as next PC, 0 selects PC + 16 |
| branch_target | input | 32 | Branch destination from decode |
| fetch_rd_en | input | 1 | Request a read of the bundle at the current PC |
| fill_en | input | 1 | Write fill_bundle into the entry at the current PC |
| fill_bundle | input | 128 | Bundle to load into the store |
| pc_o | output | 32 | Current program counter |
| ifid_npc_o | output | 32 | Registered next-sequential address for decode |
| ifid_bundle_o | output | 128 | Registered bundle for decode |

## Verification
Fill and read compete for the single store port in the same cycle. The bench raises both together while the counter advances, then expects a no-operation bundle in the decode register. A later read of that entry must return the freshly written data. A fill is also issued while fetch is frozen. The bench checks that the frozen outputs do not change, and that the following unfrozen read delivers the newly written bundle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Per-cycle decisions shared by the fetch submodules
    typedef struct packed {
        logic advance;   // PC and IF/ID may change this edge
        logic branch;    // next PC comes from the branch target
        logic write;     // store is written at the current index
        logic read;      // store output is captured into IF/ID
    } fetch_ctl_t;

endpackage

// File: rtl/fetch_pc.sv
module fetch_pc #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fetch_pkg::fetch_ctl_t ctl,
    input  logic [ADDR_W-1:0]     target,
    output logic [ADDR_W-1:0]     pc,
    output logic [ADDR_W-1:0]     pc_seq
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    assign pc_seq = st_q.pc + ADDR_W'(STEP);

    always_comb begin
        st_d = st_q;
        if (ctl.advance) begin
            st_d.pc = ctl.branch ? target : pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;
endmodule

// File: rtl/fetch_store.sv
module fetch_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] wr_word_d;

    always_comb begin
        wr_word_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wr_word_d;
        end
    end

    // Read path is registered by the IF/ID stage that follows
    assign rdata = mem_q[idx];
endmodule

// File: rtl/fetch_ifid.sv
module fetch_ifid #(
    parameter int ADDR_W   = 32,
    parameter int BUNDLE_W = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fetch_pkg::fetch_ctl_t ctl,
    input  logic [ADDR_W-1:0]     npc_in,
    input  logic [BUNDLE_W-1:0]   bundle_in,
    input  logic [BUNDLE_W-1:0]   nop_bundle,
    output logic [ADDR_W-1:0]     npc_out,
    output logic [BUNDLE_W-1:0]   bundle_out
);
    typedef struct packed {
        logic [ADDR_W-1:0]   npc;
        logic [BUNDLE_W-1:0] bundle;
    } ifid_state_t;

    ifid_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.advance) begin
            st_d.npc    = npc_in;
            st_d.bundle = ctl.read ? bundle_in : nop_bundle;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.npc    <= '0;
            st_q.bundle <= nop_bundle;
        end else begin
            st_q <= st_d;
        end
    end

    assign npc_out    = st_q.npc;
    assign bundle_out = st_q.bundle;
endmodule

// File: rtl/vliw_fetch.sv
module vliw_fetch #(
    parameter int          ADDR_W = 32,
    parameter int          OP_W   = 32,
    parameter int          SLOTS  = 4,
    parameter int          DEPTH  = 128,
    parameter logic [31:0] NOP_OP = 32'hF000_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pc_upd_en,
    input  logic                     take_branch,
    input  logic [ADDR_W-1:0]        branch_target,
    input  logic                     fetch_rd_en,
    input  logic                     fill_en,
    input  logic [OP_W*SLOTS-1:0]    fill_bundle,
    output logic [ADDR_W-1:0]        pc_o,
    output logic [ADDR_W-1:0]        ifid_npc_o,
    output logic [OP_W*SLOTS-1:0]    ifid_bundle_o
);
    localparam int BUNDLE_W = OP_W * SLOTS;
    localparam int BYTES    = BUNDLE_W / 8;
    localparam int OFF_W    = $clog2(BYTES);
    localparam int IDX_W    = $clog2(DEPTH);

    fetch_pkg::fetch_ctl_t ctl_d;
    logic [ADDR_W-1:0]     pc_q;
    logic [ADDR_W-1:0]     pc_seq;
    logic [BUNDLE_W-1:0]   store_rd;
    logic [BUNDLE_W-1:0]   nop_bundle;
    logic [IDX_W-1:0]      store_idx;

    // Slot k of the bubble sits at [OP_W*k +: OP_W] (R9)
    for (genvar k = 0; k < SLOTS; k++) begin : g_nop
        assign nop_bundle[OP_W*k +: OP_W] = OP_W'(NOP_OP);
    end

    // Byte-offset bits are dropped; index wraps at the store depth (R5)
    assign store_idx = pc_q[OFF_W +: IDX_W];

    always_comb begin
        ctl_d.advance = pc_upd_en;
        ctl_d.branch  = take_branch;
        ctl_d.write   = fill_en;
        ctl_d.read    = fetch_rd_en && !fill_en;  // fill owns the port (R6)
    end

    fetch_pc #(.ADDR_W(ADDR_W), .STEP(BYTES)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl_d),
        .target (branch_target),
        .pc     (pc_q),
        .pc_seq (pc_seq)
    );

    fetch_store #(.DEPTH(DEPTH), .DATA_W(BUNDLE_W)) u_store (
        .clk   (clk),
        .we    (ctl_d.write),
        .idx   (store_idx),
        .wdata (fill_bundle),
        .rdata (store_rd)
    );

    fetch_ifid #(.ADDR_W(ADDR_W), .BUNDLE_W(BUNDLE_W)) u_ifid (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_d),
        .npc_in     (pc_seq),
        .bundle_in  (store_rd),
        .nop_bundle (nop_bundle),
        .npc_out    (ifid_npc_o),
        .bundle_out (ifid_bundle_o)
    );

    assign pc_o = pc_q;
endmodule

// File: rtl/vliw_fetch_chk.sv
module vliw_fetch_chk #(
    parameter int          ADDR_W = 32,
    parameter int          OP_W   = 32,
    parameter int          SLOTS  = 4,
    parameter logic [31:0] NOP_OP = 32'hF000_0000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  pc_upd_en,
    input logic                  take_branch,
    input logic [ADDR_W-1:0]     branch_target,
    input logic                  fetch_rd_en,
    input logic                  fill_en,
    input logic [ADDR_W-1:0]     pc_o,
    input logic [ADDR_W-1:0]     ifid_npc_o,
    input logic [OP_W*SLOTS-1:0] ifid_bundle_o
);
    localparam int STEP = OP_W * SLOTS / 8;

    logic [OP_W*SLOTS-1:0] bubble;
    assign bubble = {SLOTS{OP_W'(NOP_OP)}};

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_state_R1: assert (pc_o == '0 && ifid_npc_o == '0 && ifid_bundle_o == bubble);
        end
    end

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_upd_en && !take_branch) |=> pc_o == $past(pc_o) + ADDR_W'(STEP));

    assert_branch_load_R3: assert property (@(posedge clk) disable iff (rst)
        (pc_upd_en && take_branch) |=> pc_o == $past(branch_target));

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !pc_upd_en |=> $stable(pc_o));

    assert_fill_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_upd_en && fill_en) |=> ifid_bundle_o == bubble);

    assert_npc_capture_R7: assert property (@(posedge clk) disable iff (rst)
        pc_upd_en |=> ifid_npc_o == $past(pc_o) + ADDR_W'(STEP));

    assert_no_read_bubble_R7: assert property (@(posedge clk) disable iff (rst)
        (pc_upd_en && !fetch_rd_en) |=> ifid_bundle_o == bubble);

    assert_ifid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !pc_upd_en |=> ($stable(ifid_npc_o) && $stable(ifid_bundle_o)));
endmodule

bind vliw_fetch vliw_fetch_chk #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .SLOTS(SLOTS), .NOP_OP(NOP_OP)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc_upd_en     (pc_upd_en),
    .take_branch   (take_branch),
    .branch_target (branch_target),
    .fetch_rd_en   (fetch_rd_en),
    .fill_en       (fill_en),
    .pc_o          (pc_o),
    .ifid_npc_o    (ifid_npc_o),
    .ifid_bundle_o (ifid_bundle_o)
);

// File: tb/vliw_fetch_test.sv
module vliw_fetch_test;
    localparam logic [31:0] NOP = 32'hF000_0000;
    localparam logic [7:0]  BUB = 8'hFF;   // expected-bubble marker in the table

    typedef struct packed {
        logic        upd, sel, rd, fill;
        logic [31:0] tgt;
        logic [7:0]  seed;
        logic [31:0] epc, enpc;
        logic [7:0]  eseed;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1, 32'h0,        8'd9,  32'h0,        32'h0,   BUB},    // R5 R8 fill while frozen
        '{1'b1,1'b0,1'b1,1'b1, 32'h0,        8'd10, 32'h10,       32'h10,  BUB},    // R6 fill beats read
        '{1'b1,1'b0,1'b0,1'b1, 32'h0,        8'd11, 32'h20,       32'h20,  BUB},    // R2 R7
        '{1'b0,1'b0,1'b0,1'b1, 32'h0,        8'd12, 32'h20,       32'h20,  BUB},    // R4 R5
        '{1'b1,1'b1,1'b0,1'b0, 32'h0,        8'd0,  32'h0,        32'h30,  BUB},    // R3
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h10,       32'h10,  8'd10},  // R7 R6 write landed
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h20,       32'h20,  8'd11},  // R7 R9
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h20,       32'h20,  8'd11},  // R8 R4
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h30,       32'h30,  8'd12},  // R7
        '{1'b1,1'b1,1'b0,1'b0, 32'h807,      8'd0,  32'h807,      32'h40,  BUB},    // R3
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h817,      32'h817, 8'd10},  // R5 offset/alias
        '{1'b1,1'b1,1'b0,1'b0, 32'hFFFFFFF0, 8'd0,  32'hFFFFFFF0, 32'h827, BUB},    // R3
        '{1'b1,1'b0,1'b0,1'b0, 32'h0,        8'd0,  32'h0,        32'h0,   BUB},    // R2 wrap
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h10,       32'h10,  8'd10},  // R7
        '{1'b0,1'b0,1'b1,1'b1, 32'h0,        8'd20, 32'h10,       32'h10,  8'd10},  // R8 R5 fill while frozen
        '{1'b1,1'b0,1'b1,1'b0, 32'h0,        8'd0,  32'h20,       32'h20,  8'd20}   // R5 fresh data
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pc_upd_en = 1'b0, take_branch = 1'b0, fetch_rd_en = 1'b0, fill_en = 1'b0;
    logic [31:0]  branch_target = '0;
    logic [127:0] fill_bundle = '0;
    logic [31:0]  pc_o, ifid_npc_o;
    logic [127:0] ifid_bundle_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    vliw_fetch uut (
        .clk(clk), .rst(rst), .pc_upd_en(pc_upd_en), .take_branch(take_branch),
        .branch_target(branch_target), .fetch_rd_en(fetch_rd_en), .fill_en(fill_en),
        .fill_bundle(fill_bundle), .pc_o(pc_o), .ifid_npc_o(ifid_npc_o),
        .ifid_bundle_o(ifid_bundle_o)
    );

    // Slot k holds {16'hB00C, k, seed} at bits [32k+31:32k] (R9)
    function automatic logic [127:0] mk(input logic [7:0] s);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) r[32*k +: 32] = {16'hB00C, 8'(k), s};
        return r;
    endfunction

    task automatic chk32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s bundle: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk32("R1", "pc", pc_o, 32'h0);
        chk32("R1", "npc", ifid_npc_o, 32'h0);
        chk128("R1", ifid_bundle_o, {4{NOP}});
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pc_upd_en     = VECS[i].upd;
            take_branch   = VECS[i].sel;
            fetch_rd_en   = VECS[i].rd;
            fill_en       = VECS[i].fill;
            branch_target = VECS[i].tgt;
            fill_bundle   = mk(VECS[i].seed);
            @(negedge clk);
            chk32("R2/R3/R4", "pc", pc_o, VECS[i].epc);
            chk32("R7/R8", "npc", ifid_npc_o, VECS[i].enpc);
            chk128("R5/R6/R7/R8/R9", ifid_bundle_o,
                   (VECS[i].eseed == BUB) ? {4{NOP}} : mk(VECS[i].eseed));
        end

        // R1: reset in mid-run with a branch pending is obeyed
        pc_upd_en = 1'b1; take_branch = 1'b1; branch_target = 32'h1230; fetch_rd_en = 1'b1; fill_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk32("R1", "pc", pc_o, 32'h0);
        chk32("R1", "npc", ifid_npc_o, 32'h0);
        chk128("R1", ifid_bundle_o, {4{NOP}});
        rst = 1'b0;

        // R7 after reset: store contents survive, entry 0 is read back
        take_branch = 1'b0;
        @(negedge clk);
        chk32("R2", "pc", pc_o, 32'h10);
        chk128("R7", ifid_bundle_o, mk(8'd10));

        finish_run();
    end
endmodule